// File: doc/BRIEF.md
# Two-Wire Controller Byte FIFO Pair

This block holds the bytes a two-wire serial bus controller sends and receives: a transmit FIFO filled by software and drained by the protocol engine, and a receive FIFO filled by the engine and drained by software. Both are 16 bytes deep. Each one reports its live occupancy on a 5-bit level output, along with full and empty indications. Each also raises one-cycle flags when a push or a pop is refused.

Both FIFOs are emptied automatically, without a reset, when the controller is switched off and when the engine reports a transmit abort. A separate abort of a slave bulk transmit empties only the transmit side. Each flush clears both the level and the pointers, so the first byte pushed after a flush is the first one popped.

Top module: `twi_fifo_pair`

## Requirements
- R1: After reset both levels are 0, both empty outputs are 1, both full outputs are 0, and all overflow and underflow flags are 0.
- R2: With no flush, an accepted push raises the level by one and an accepted pop lowers it by one. The new level appears on the level output after the clock edge that accepts the operation.
- R3: A push and a pop accepted on the same edge leave the level unchanged.
- R4: Bytes leave in the order they were pushed. While a FIFO is non-empty, its read data output shows the oldest stored byte, with no wait after the edge that changes it.
- R5: Full is 1 exactly when the level is 16, and empty is 1 exactly when the level is 0.
- R6: A push is accepted only if the level before the edge is below 16, even when a pop arrives on the same edge. A refused push stores nothing, and the overflow flag of that FIFO is 1 for exactly the cycle after that edge.
- R7: A pop when the level is 0 is refused and changes nothing. The underflow flag of that FIFO is 1 for exactly the cycle after that edge.
- R8: While enable is 0, both FIFOs are held empty at level 0, and pushes and pops are ignored without raising any flag.
- R9: A transmit-abort pulse empties both FIFOs, and both levels read 0 after that edge.
- R10: A slave bulk-transmit-abort pulse empties only the transmit FIFO. The receive level and its contents stay as they were, apart from that cycle's receive push or pop.
- R11: A flush takes priority over a push or pop on the same edge for the affected FIFO. The operation is dropped and no overflow or underflow flag is raised. After a flush, the next pushed byte is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; 0 flushes both FIFOs |
| tx_abort | input | 1 | Transmit-abort pulse; flushes both FIFOs |
| slv_tx_abort | input | 1 | Slave bulk-transmit-abort pulse; flushes transmit FIFO |
| tx_push | input | 1 | Push request, transmit FIFO |
| tx_wdata | input | 8 | Byte to push, transmit FIFO |
| tx_pop | input | 1 | Pop request, transmit FIFO |
| tx_rdata | output | 8 | Oldest byte, transmit FIFO |
| tx_level | output | 5 | Occupancy, transmit FIFO |
| tx_full | output | 1 | Transmit level equals 16 |
| tx_empty | output | 1 | Transmit level equals 0 |
| tx_ovf | output | 1 | Refused transmit push, one cycle |
| tx_udf | output | 1 | Refused transmit pop, one cycle |
| rx_push | input | 1 | Push request, receive FIFO |
| rx_wdata | input | 8 | Byte to push, receive FIFO |
| rx_pop | input | 1 | Pop request, receive FIFO |
| rx_rdata | output | 8 | Oldest byte, receive FIFO |
| rx_level | output | 5 | Occupancy, receive FIFO |
| rx_full | output | 1 | Receive level equals 16 |
| rx_empty | output | 1 | Receive level equals 0 |
| rx_ovf | output | 1 | Refused receive push, one cycle |
| rx_udf | output | 1 | Refused receive pop, one cycle |

## Verification
A counter that drifts away from the pointer distance shows up on the level output one cycle after the faulty edge. Later it also shows up as a wrong byte on the read data port, or as a full or empty output that does not match the true content. A flush that fails to reset the pointers leaves the level at zero, but stale bytes appear on read data as soon as the next push arrives. The bench therefore compares level, flags and read data every cycle against a queue model, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/twi_fifo_pair.sv
module twi_fifo_pair #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enable,
  input  logic                           tx_abort,
  input  logic                           slv_tx_abort,
  input  logic                           tx_push,
  input  logic [DW-1:0]                  tx_wdata,
  input  logic                           tx_pop,
  output logic [DW-1:0]                  tx_rdata,
  output logic [$clog2(DEPTH+1)-1:0]     tx_level,
  output logic                           tx_full,
  output logic                           tx_empty,
  output logic                           tx_ovf,
  output logic                           tx_udf,
  input  logic                           rx_push,
  input  logic [DW-1:0]                  rx_wdata,
  input  logic                           rx_pop,
  output logic [DW-1:0]                  rx_rdata,
  output logic [$clog2(DEPTH+1)-1:0]     rx_level,
  output logic                           rx_full,
  output logic                           rx_empty,
  output logic                           rx_ovf,
  output logic                           rx_udf
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [1:0]    flush, push, pop, ovf, udf;
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [LW-1:0] lvl   [2];

  assign flush = {~enable | tx_abort, ~enable | tx_abort | slv_tx_abort};
  assign push  = {rx_push, tx_push};
  assign pop   = {rx_pop, tx_pop};
  assign wdata[0] = tx_wdata;
  assign wdata[1] = rx_wdata;

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          ovf_q, udf_q;
    logic          push_ok, pop_ok;

    assign push_ok = push[g] && !flush[g] && (cnt != LW'(DEPTH));
    assign pop_ok  = pop[g]  && !flush[g] && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0; ovf_q <= 1'b0; udf_q <= 1'b0;
      end else if (flush[g]) begin
        wp <= '0; rp <= '0; cnt <= '0; ovf_q <= 1'b0; udf_q <= 1'b0;
      end else begin
        ovf_q <= push[g] && !push_ok;
        udf_q <= pop[g] && !pop_ok;
        if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
        if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
        else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (push_ok) mem[wp] <= wdata[g];

    assign rdata[g] = mem[rp];
    assign lvl[g]   = cnt;
    assign ovf[g]   = ovf_q;
    assign udf[g]   = udf_q;
  end

  assign tx_rdata = rdata[0];
  assign tx_level = lvl[0];
  assign tx_full  = lvl[0] == LW'(DEPTH);
  assign tx_empty = lvl[0] == '0;
  assign tx_ovf   = ovf[0];
  assign tx_udf   = udf[0];
  assign rx_rdata = rdata[1];
  assign rx_level = lvl[1];
  assign rx_full  = lvl[1] == LW'(DEPTH);
  assign rx_empty = lvl[1] == '0;
  assign rx_ovf   = ovf[1];
  assign rx_udf   = udf[1];
endmodule

// File: rtl/twi_fifo_pair_chk.sv
module twi_fifo_pair_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic                       tx_abort,
  input logic                       slv_tx_abort,
  input logic                       tx_push,
  input logic                       tx_pop,
  input logic [$clog2(DEPTH+1)-1:0] tx_level,
  input logic                       tx_full,
  input logic                       tx_ovf,
  input logic                       tx_udf,
  input logic                       rx_push,
  input logic                       rx_pop,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic                       rx_ovf,
  input logic                       rx_udf
);
  localparam int LW = $clog2(DEPTH+1);

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || tx_abort || slv_tx_abort) |=> (tx_level == '0 && !tx_ovf && !tx_udf)); // R11
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || tx_abort) |=> (rx_level == '0 && !rx_ovf && !rx_udf)); // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tx_abort && !slv_tx_abort && tx_full && tx_push && !tx_pop)
    |=> (tx_ovf && tx_level == LW'(DEPTH))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tx_abort && !slv_tx_abort && tx_level == '0 && tx_pop && !tx_push)
    |=> (tx_udf && tx_level == '0)); // R7
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tx_abort && !slv_tx_abort && tx_push && !tx_pop && !tx_full)
    |=> (tx_level == $past(tx_level) + 1'b1)); // R2
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tx_abort && !slv_tx_abort && tx_push && tx_pop && tx_level != '0 && !tx_full)
    |=> $stable(tx_level)); // R3
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tx_abort && slv_tx_abort && !rx_push && !rx_pop) |=> $stable(rx_level)); // R10
endmodule

bind twi_fifo_pair twi_fifo_pair_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_twi_fifo_pair.sv
module test_twi_fifo_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, tx_abort = 1'b0, slv_tx_abort = 1'b0;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [4:0] tx_level, rx_level;
  logic tx_full, tx_empty, tx_ovf, tx_udf, rx_full, rx_empty, rx_ovf, rx_udf;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] tq[$], rq[$];
  bit e_tovf, e_tudf, e_rovf, e_rudf;

  always #10 clk = ~clk;

  twi_fifo_pair i_twi_fifo_pair (.*);

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit ovf_of(bit p, int n); return p && n >= 16; endfunction
  function automatic bit udf_of(bit p, int n); return p && n == 0; endfunction

  task automatic model_step();
    bit tfl = !enable || tx_abort || slv_tx_abort;
    bit rfl = !enable || tx_abort;
    e_tovf = 0; e_tudf = 0; e_rovf = 0; e_rudf = 0;
    if (tfl) tq.delete();
    else begin
      int n = tq.size();
      e_tovf = ovf_of(tx_push, n); e_tudf = udf_of(tx_pop, n);
      if (tx_pop && n > 0) void'(tq.pop_front());
      if (tx_push && n < 16) tq.push_back(tx_wdata);
    end
    if (rfl) rq.delete();
    else begin
      int n = rq.size();
      e_rovf = ovf_of(rx_push, n); e_rudf = udf_of(rx_pop, n);
      if (rx_pop && n > 0) void'(rq.pop_front());
      if (rx_push && n < 16) rq.push_back(rx_wdata);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, tx_level, tq.size(), "tx_level");
    chk(tag, rx_level, rq.size(), "rx_level");
    chk("R5", tx_full, tq.size() == 16, "tx_full");
    chk("R5", tx_empty, tq.size() == 0, "tx_empty");
    chk("R5", rx_full, rq.size() == 16, "rx_full");
    chk("R5", rx_empty, rq.size() == 0, "rx_empty");
    chk("R6", tx_ovf, e_tovf, "tx_ovf");
    chk("R6", rx_ovf, e_rovf, "rx_ovf");
    chk("R7", tx_udf, e_tudf, "tx_udf");
    chk("R7", rx_udf, e_rudf, "rx_udf");
    if (tq.size() > 0) chk("R4", tx_rdata, tq[0], "tx_rdata");
    if (rq.size() > 0) chk("R4", rx_rdata, rq[0], "rx_rdata");
  endtask

  task automatic cyc(string tag, bit en, bit ab, bit sab, bit tpu, bit tpo, bit rpu, bit rpo);
    enable = en; tx_abort = ab; slv_tx_abort = sab;
    tx_push = tpu; tx_pop = tpo; rx_push = rpu; rx_pop = rpo;
    tx_wdata = 8'($urandom); rx_wdata = 8'($urandom);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    e_tovf = 0; e_tudf = 0; e_rovf = 0; e_rudf = 0;
    #5;
    chk("R1", tx_level, 0, "tx_level reset"); chk("R1", rx_level, 0, "rx_level reset");
    chk("R1", tx_empty, 1, "tx_empty reset"); chk("R1", tx_full, 0, "tx_full reset");
    chk("R1", tx_ovf | tx_udf | rx_ovf | rx_udf, 0, "flags reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");
    cyc("R7", 1, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 18; i++) cyc("R6", 1, 0, 0, 1, 0, 1, 0);
    cyc("R6", 1, 0, 0, 1, 1, 1, 1);
    cyc("R3", 1, 0, 0, 1, 1, 1, 1);
    cyc("R10", 1, 0, 1, 1, 0, 0, 0);
    chk("R10", rx_level, 15, "rx kept on slave abort");
    cyc("R2", 1, 0, 0, 1, 0, 0, 1);
    cyc("R9", 1, 1, 0, 1, 1, 1, 1);
    chk("R9", tx_level + rx_level, 0, "both cleared");
    cyc("R11", 1, 0, 0, 1, 0, 1, 0);
    cyc("R11", 1, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 3; i++) cyc("R2", 1, 0, 0, 1, 0, 1, 0);
    cyc("R8", 0, 0, 0, 1, 1, 1, 1);
    cyc("R8", 0, 0, 0, 1, 0, 0, 1);
    chk("R8", tx_level + rx_level, 0, "disabled empty");
    for (int ph = 0; ph < 4; ph++) begin
      int pp = (ph == 0) ? 80 : (ph == 1) ? 20 : 50;
      for (int i = 0; i < 800; i++) begin
        bit en = ($urandom % 100) >= 2;
        bit ab = ($urandom % 100) < 2;
        bit sab = ($urandom % 100) < 2;
        cyc("R2", en, ab, sab,
            ($urandom % 100) < pp, ($urandom % 100) >= pp,
            ($urandom % 100) < pp, ($urandom % 100) >= pp);
      end
    end
    finish_run();
  end
endmodule